// File: doc/BRIEF.md
# Packed FP8 Pack/Unpack Converter

This datapath moves values between 32-bit single-precision floats and 8-bit floats stored four to a 32-bit word. It offers three operations, chosen per cycle by an operation code. Extract takes one byte from a packed word and widens it exactly to single precision. Pair-pack rounds two floats to the nearest 8-bit value, ties to even, and places them in the lower or upper half of the word. Stochastic-pack rounds one float after adding bits of a caller-supplied random word and places it in one chosen byte. Both 8-bit formats have no negative zero and a single NaN code: one with 4 exponent and 3 mantissa bits, the other with 5 and 2.

For the two pack operations, the bytes that are not written come from an existing packed word when the caller flags it as present. Otherwise they are driven to zero. Every operation is registered once, so a request accepted on one clock edge shows up on the outputs after that edge, together with an output valid flag.

Top module: `fp8_pack_unit`

## Requirements
- R1: While rst_ni is low, and after it is released until the first accepted request, valid_o is 0 and result_o is 0.
- R2: valid_o is valid_i delayed by one clock. The result of a request accepted at an edge appears at that edge. result_o keeps its value when valid_i is low.
- R3: Extract (op_i = 0) widens element idx_i, which sits in word_i bits [8*idx_i+7 : 8*idx_i], to its exact single-precision value.
- R4: On extract, code 0x80 gives 0x7FC00000 and code 0x00 gives +0.0. Subnormal codes give their exact normalized value (for example 0x05 in the 4/3 format gives 0x3BA00000).
- R5: Pair-pack (op_i = 1) writes the code of src_a_i to byte 2*idx_i[0] and the code of src_b_i to byte 2*idx_i[0]+1. idx_i[1] is ignored.
- R6: For pair-pack and stochastic-pack, every byte not written is taken from word_i when has_exist_i is 1 and is 0x00 otherwise.
- R7: On pair-pack with has_b_i = 0, the byte meant for src_b_i is 0x00.
- R8: Pair-pack rounds to nearest with ties to even. This holds in the subnormal range and when a carry moves the value into the next exponent.
- R9: Finite magnitudes above the format maximum and infinities saturate to code 0x7F with the input's sign bit. Any NaN gives 0x80. A result of zero magnitude is always 0x00, whatever the input sign.
- R10: Stochastic-pack (op_i = 2) writes to byte idx_i. It adds the low s bits of rand_i to the s discarded significand bits, increments the kept value on a carry out, and then truncates. Higher bits of rand_i have no effect.
- R11: Single-precision denormals, and inputs below a quarter of the smallest 8-bit subnormal, encode to 0x00 in both rounding modes.
- R12: fmt_i = 0 selects the 4-exponent/3-mantissa format with bias 8 (maximum 240). fmt_i = 1 selects the 5-exponent/2-mantissa format with bias 16 (maximum 57344).
- R13: op_i = 3 produces an all-zero result word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request accepted at this edge |
| op_i | input | 2 | 0 extract, 1 pair-pack, 2 stochastic-pack, 3 reserved |
| fmt_i | input | 1 | 8-bit format select |
| idx_i | input | 2 | Element index; bit 0 selects the half for pair-pack |
| has_b_i | input | 1 | Second pair-pack source present |
| has_exist_i | input | 1 | Existing word present for merge |
| word_i | input | 32 | Packed source for extract, existing word for pack |
| src_a_i | input | 32 | First single-precision source |
| src_b_i | input | 32 | Second single-precision source |
| rand_i | input | 32 | Random word for stochastic rounding |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Widened float or packed word |

## Verification
Rounding and merging happen in the same cycle. A pair-pack converts two floats and also copies the two untouched bytes of the existing word. A stochastic-pack rounds one float and also keeps three bytes. Vectors supply a recognizable existing word together with sources whose rounding carries, ties or saturates. The bench compares the whole output word, so an error in placement and an error in rounding are each caught. Requests are also issued back to back with different operation codes, so that the results of an extract and a pack on consecutive edges are checked against one another.

// File: rtl/fp8_pkg.sv
`timescale 1ns/1ps
package fp8_pkg;
  typedef enum logic [1:0] {
    OP_EXTRACT = 2'd0,
    OP_PAIR    = 2'd1,
    OP_STOCH   = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  localparam int NUM_FMT  = 2;   // 0: 4e/3m, 1: 5e/2m
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 32;
  localparam int NUM_ELEM = WORD_W / BYTE_W;
  localparam logic [31:0] F32_QNAN = 32'h7FC0_0000;
  localparam logic [7:0]  FP8_NAN  = 8'h80;
endpackage

// File: rtl/fp8_decode.sv
`timescale 1ns/1ps
module fp8_decode #(
  parameter int EW = 4,
  parameter int MW = 3
) (
  input  logic [7:0]  code_i,
  output logic [31:0] f_o
);
  localparam int BIAS = 1 << (EW - 1);

  logic          s;
  logic [EW-1:0] e;
  logic [MW-1:0] m;
  logic [22:0]   frac;
  int            lead;

  assign s = code_i[7];
  assign e = code_i[6:MW];
  assign m = code_i[MW-1:0];

  always_comb begin
    lead = 0;
    for (int i = 0; i < MW; i++) if (m[i]) lead = i;
    frac = (23'(m) & ~(23'd1 << lead)) << (23 - lead);
    if (code_i == fp8_pkg::FP8_NAN)
      f_o = fp8_pkg::F32_QNAN;
    else if (code_i[6:0] == 7'd0)
      f_o = '0;
    else if (e != '0)
      f_o = {s, 8'(int'(e) - BIAS + 127), m, {(23-MW){1'b0}}};
    else  // subnormal: renormalize on leading one
      f_o = {s, 8'(lead + 1 - BIAS - MW + 127), frac};
  end
endmodule

// File: rtl/fp8_encode.sv
`timescale 1ns/1ps
module fp8_encode #(
  parameter int EW = 4,
  parameter int MW = 3
) (
  input  logic [31:0] f_i,
  input  logic        stoch_i,
  input  logic [31:0] rand_i,
  output logic [7:0]  code_o
);
  localparam int BIAS  = 1 << (EW - 1);
  localparam int EMIN  = 1 - BIAS;
  localparam int MAXC  = (1 << (EW + MW)) - 1;
  localparam int SHMAX = 25;

  logic        sign, is_nan, is_inf, inc;
  logic [7:0]  ef;
  logic [23:0] sig;
  logic [31:0] kept, mask, rem, half, rsum, rnd;
  int          ue, te, sh, c, mag;

  assign sign   = f_i[31];
  assign ef     = f_i[30:23];
  assign sig    = {ef != 8'd0, f_i[22:0]};
  assign is_nan = (ef == 8'hFF) && (f_i[22:0] != '0);
  assign is_inf = (ef == 8'hFF) && (f_i[22:0] == '0);

  always_comb begin
    ue   = (ef == 8'd0) ? -126 : int'(ef) - 127;
    te   = (ue > EMIN) ? ue : EMIN;
    sh   = 23 - MW + (te - ue);
    kept = '0; mask = '0; rem = '0; half = '0; rsum = '0; rnd = '0;
    inc  = 1'b0; c = 0; mag = 0;
    if (sh <= SHMAX) begin
      kept = {8'd0, sig} >> sh;
      mask = (32'd1 << sh) - 32'd1;
      rem  = {8'd0, sig} & mask;
      half = 32'd1 << (sh - 1);
      rsum = rem + (rand_i & mask);
      inc  = stoch_i ? (rsum > mask)
                     : ((rem > half) || ((rem == half) && kept[0]));
      rnd  = kept + {31'd0, inc};
      c    = ((te + BIAS - 1) << MW) + int'(rnd);
      mag  = (c > MAXC) ? MAXC : c;
    end
  end

  always_comb begin
    if (is_nan)        code_o = fp8_pkg::FP8_NAN;
    else if (is_inf)   code_o = {sign, 7'(MAXC)};
    else if (mag == 0) code_o = 8'h00;
    else               code_o = {sign, 7'(mag)};
  end
endmodule

// File: rtl/fp8_pack_unit.sv
`timescale 1ns/1ps
module fp8_pack_unit
  import fp8_pkg::*;
#(
  parameter int IDX_W = $clog2(NUM_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              fmt_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              has_b_i,
  input  logic              has_exist_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] src_a_i,
  input  logic [WORD_W-1:0] src_b_i,
  input  logic [WORD_W-1:0] rand_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o
);
  localparam int HALF_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] enc_a [NUM_FMT];
  logic [BYTE_W-1:0] enc_b [NUM_FMT];
  logic [WORD_W-1:0] dec_f [NUM_FMT];
  logic [BYTE_W-1:0] sel_byte, code_a, code_b;
  logic [WORD_W-1:0] base, nxt;
  logic              is_stoch;

  assign is_stoch = (op_e'(op_i) == OP_STOCH);
  assign sel_byte = word_i[BYTE_W*idx_i +: BYTE_W];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = 4 + g;
    localparam int MW = 3 - g;
    fp8_encode #(.EW(EW), .MW(MW)) u_enc_a (
      .f_i(src_a_i), .stoch_i(is_stoch), .rand_i(rand_i), .code_o(enc_a[g]));
    fp8_encode #(.EW(EW), .MW(MW)) u_enc_b (
      .f_i(src_b_i), .stoch_i(1'b0), .rand_i(rand_i), .code_o(enc_b[g]));
    fp8_decode #(.EW(EW), .MW(MW)) u_dec (
      .code_i(sel_byte), .f_o(dec_f[g]));
  end

  assign code_a = enc_a[fmt_i];
  assign code_b = has_b_i ? enc_b[fmt_i] : '0;
  assign base   = has_exist_i ? word_i : '0;

  always_comb begin
    nxt = base;
    unique case (op_e'(op_i))
      OP_EXTRACT: nxt = dec_f[fmt_i];
      OP_PAIR: begin
        nxt[HALF_W*idx_i[0] +: BYTE_W]          = code_a;
        nxt[HALF_W*idx_i[0] + BYTE_W +: BYTE_W] = code_b;
      end
      OP_STOCH: nxt[BYTE_W*idx_i +: BYTE_W] = code_a;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
  p_nan_widen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && sel_byte == 8'h80) |=> result_o == 32'h7FC0_0000);
  p_merge_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && has_exist_i && !idx_i[0])
      |=> result_o[31:16] == $past(word_i[31:16]));
  p_merge_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && has_exist_i && idx_i[0])
      |=> result_o[15:0] == $past(word_i[15:0]));
  p_absent_b_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && !has_b_i && !idx_i[0]) |=> result_o[15:8] == 8'h00);
  p_absent_b_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && !has_b_i && idx_i[0]) |=> result_o[31:24] == 8'h00);
  p_rsvd_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3) |=> result_o == '0);
endmodule

// File: tb/fp8_pack_unit_test.sv
`timescale 1ns/1ps
module fp8_pack_unit_test;
  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic        fmt;
    logic [1:0]  idx;
    logic        hb;
    logic        hx;
    logic [31:0] word;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] rnd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    // encoder through pair-pack, half 0, no b, no existing word
    '{4'd5,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3F80_0000, 32'h0, 32'h0, 32'h0000_0040}, // R5 1.0
    '{4'd5,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'hC000_0000, 32'h0, 32'h0, 32'h0000_00C8}, // R5 -2.0
    '{4'd12, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h4370_0000, 32'h0, 32'h0, 32'h0000_007F}, // R12 240
    '{4'd9,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h447A_0000, 32'h0, 32'h0, 32'h0000_007F}, // R9 1000
    '{4'd9,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'hC47A_0000, 32'h0, 32'h0, 32'h0000_00FF}, // R9 -1000
    '{4'd9,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h7F80_0000, 32'h0, 32'h0, 32'h0000_007F}, // R9 inf
    '{4'd9,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h7FC0_0000, 32'h0, 32'h0, 32'h0000_0080}, // R9 NaN
    '{4'd9,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h8000_0000, 32'h0, 32'h0, 32'h0000_0000}, // R9 -0
    '{4'd8,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3F88_0000, 32'h0, 32'h0, 32'h0000_0040}, // R8 tie even down
    '{4'd8,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3F98_0000, 32'h0, 32'h0, 32'h0000_0042}, // R8 tie odd up
    '{4'd8,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3A00_0000, 32'h0, 32'h0, 32'h0000_0000}, // R8 subnormal tie
    '{4'd8,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3A40_0000, 32'h0, 32'h0, 32'h0000_0001}, // R8 subnormal up
    '{4'd8,  2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3B40_0000, 32'h0, 32'h0, 32'h0000_0003}, // R8 exact sub
    '{4'd12, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3F80_0000, 32'h0, 32'h0, 32'h0000_0040}, // R12 5e2m 1.0
    '{4'd12, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 32'h4760_0000, 32'h0, 32'h0, 32'h0000_007F}, // R12 5e2m max
    '{4'd12, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3FC0_0000, 32'h0, 32'h0, 32'h0000_0042}, // R12 5e2m 1.5
    '{4'd8,  2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 32'h4370_0000, 32'h0, 32'h0, 32'h0000_0060}, // R8 carry exp
    '{4'd11, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3880_0000, 32'h0, 32'h0, 32'h0000_0000}, // R11 tiny
    '{4'd11, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0001, 32'h0, 32'h0, 32'h0000_0000}, // R11 denorm
    // placement and merge
    '{4'd5,  2'd1, 1'b0, 2'd0, 1'b1, 1'b1, 32'hAABB_CCDD, 32'h3F80_0000, 32'hC000_0000, 32'h0, 32'hAABB_C840}, // R5 R6
    '{4'd5,  2'd1, 1'b0, 2'd1, 1'b1, 1'b1, 32'hAABB_CCDD, 32'h3F80_0000, 32'hC000_0000, 32'h0, 32'hC840_CCDD}, // R5 R6
    '{4'd7,  2'd1, 1'b0, 2'd3, 1'b0, 1'b1, 32'hAABB_CCDD, 32'h3F80_0000, 32'hC000_0000, 32'h0, 32'h0040_CCDD}, // R7 R5 idx bit1
    '{4'd6,  2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 32'hAABB_CCDD, 32'h3F80_0000, 32'hC000_0000, 32'h0, 32'h0000_C840}, // R6
    // stochastic
    '{4'd10, 2'd2, 1'b0, 2'd2, 1'b0, 1'b1, 32'h1122_3344, 32'h3F88_0000, 32'h0, 32'h0008_0000, 32'h1141_3344}, // R10 carry
    '{4'd10, 2'd2, 1'b0, 2'd2, 1'b0, 1'b1, 32'h1122_3344, 32'h3F88_0000, 32'h0, 32'h0007_FFFF, 32'h1140_3344}, // R10 no carry
    '{4'd10, 2'd2, 1'b0, 2'd2, 1'b0, 1'b1, 32'h1122_3344, 32'h3F88_0000, 32'h0, 32'hFFF0_0000, 32'h1140_3344}, // R10 high bits
    '{4'd6,  2'd2, 1'b0, 2'd3, 1'b0, 1'b0, 32'h1122_3344, 32'h3F80_0000, 32'h0, 32'hFFFF_FFFF, 32'h4000_0000}, // R6 R10
    '{4'd11, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h3880_0000, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000},       // R11 stoch
    // extract
    '{4'd3,  2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h01C8_4080, 32'h0, 32'h0, 32'h0, 32'h3F80_0000}, // R3
    '{4'd3,  2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h01C8_4080, 32'h0, 32'h0, 32'h0, 32'hC000_0000}, // R3
    '{4'd4,  2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 32'h01C8_4080, 32'h0, 32'h0, 32'h0, 32'h3A80_0000}, // R4 sub
    '{4'd4,  2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h01C8_4080, 32'h0, 32'h0, 32'h0, 32'h7FC0_0000}, // R4 NaN
    '{4'd4,  2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0005, 32'h0, 32'h0, 32'h0, 32'h3BA0_0000}, // R4 sub 5
    '{4'd4,  2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 32'h0, 32'h0000_0000}, // R4 zero
    '{4'd12, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_017F, 32'h0, 32'h0, 32'h0, 32'h4760_0000}, // R12 max
    '{4'd12, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_017F, 32'h0, 32'h0, 32'h0, 32'h3700_0000}, // R12 sub
    '{4'd3,  2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_007F, 32'h0, 32'h0, 32'h0, 32'h4370_0000}, // R3 max
    '{4'd13, 2'd3, 1'b0, 2'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h3F80_0000, 32'h3F80_0000, 32'h0, 32'h0} // R13
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        fmt_i = 1'b0;
  logic [1:0]  idx_i = '0;
  logic        has_b_i = 1'b0;
  logic        has_exist_i = 1'b0;
  logic [31:0] word_i = '0, src_a_i = '0, src_b_i = '0, rand_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk_i = ~clk_i;

  fp8_pack_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .fmt_i(fmt_i),
    .idx_i(idx_i), .has_b_i(has_b_i), .has_exist_i(has_exist_i), .word_i(word_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .rand_i(rand_i),
    .valid_o(valid_o), .result_o(result_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    check("R1 result in reset", result_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 result after release", result_o, 32'd0);
    for (int i = 0; i < NV; i++) begin
      op_i = VECS[i].op; fmt_i = VECS[i].fmt; idx_i = VECS[i].idx;
      has_b_i = VECS[i].hb; has_exist_i = VECS[i].hx; word_i = VECS[i].word;
      src_a_i = VECS[i].a; src_b_i = VECS[i].b; rand_i = VECS[i].rnd;
      valid_i = 1'b1;
      @(negedge clk_i);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), result_o, VECS[i].exp);
      check($sformatf("R2 valid vector %0d", i), {31'd0, valid_o}, 32'd1);
    end
    // R2: idle cycles hold the last result while inputs change
    valid_i = 1'b0; op_i = 2'd1; src_a_i = 32'h3F80_0000; has_exist_i = 1'b1; word_i = 32'h1234_5678;
    @(negedge clk_i);
    check("R2 valid drops", {31'd0, valid_o}, 32'd0);
    check("R2 result held", result_o, 32'h0);
    @(negedge clk_i);
    check("R2 result still held", result_o, 32'h0);
    // R3 then R5 back to back
    valid_i = 1'b1; op_i = 2'd0; fmt_i = 1'b0; idx_i = 2'd1; word_i = 32'h0000_4800;
    @(negedge clk_i);
    check("R3 extract back-to-back", result_o, 32'h4000_0000);
    op_i = 2'd1; idx_i = 2'd1; has_b_i = 1'b1; has_exist_i = 1'b1;
    word_i = 32'hDEAD_BEEF; src_a_i = 32'hC000_0000; src_b_i = 32'h3F80_0000;
    @(negedge clk_i);
    check("R5 pack back-to-back", result_o, 32'h40C8_BEEF);
    valid_i = 1'b0;
    // R1: reset mid-run clears state
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset clears result", result_o, 32'h0);
    check("R1 reset clears valid", {31'd0, valid_o}, 32'd0);
    finish_run();
  end
endmodule